// File: doc/BRIEF.md
# DMA Channel Address and Word-Count Unit

This block is a single transfer channel of a direct-memory-access controller. Software programs three registers through a small write port: a mode byte, a start address and a word count. A peripheral then raises its request line. The channel forwards a bus request to an external arbiter. For every cycle in which the arbiter grants, the channel presents the current memory address and strobes for the selected transfer type. It then steps its address and count.

The channel supports three ways of holding the bus: one word per request, a whole block, or for as long as the peripheral keeps requesting. It can re-arm itself when the count runs out. It can also pin the address for memory-to-memory source use, and it can run a verify pass that walks addresses and counts without touching memory. Arbitration between channels, bus multiplexing and the data path belong to neighbouring blocks.

The control state machine has two states. `S_IDLE`: no bus request is driven. `S_ACTIVE`: a bus request is driven while the mode allows it. The transitions are:
- **start**: `S_IDLE` to `S_ACTIVE` when the channel is unmasked, the mode is usable and `dev_req` is high.
- **finish**: `S_ACTIVE` to `S_IDLE` on terminal count.
- **release**: `S_ACTIVE` to `S_IDLE` after a granted word in single mode.
- **pause**: `S_ACTIVE` to `S_IDLE` when `dev_req` is low in demand mode.
- **cancel**: `S_ACTIVE` to `S_IDLE` when the mode becomes unusable.
- **hold**: `S_ACTIVE` stays in `S_ACTIVE` otherwise.

Top module: `dma_chan_unit`

## Requirements
- R1: After reset, `bus_req`, `rd_stb`, `wr_stb` and `term_cnt` are 0 and `mem_addr` is 0. The channel is masked, so `dev_req` produces no `bus_req` until the address or count register is written.
- R2: Mode bits [1:0] set the transfer type: 0 is verify, 1 is write, 2 is read, 3 is illegal. On a granted word, read drives `rd_stb` only, write drives `wr_stb` only, and verify drives neither. The illegal code never raises `bus_req`.
- R3: Mode bit 3 set makes the address decrement by one after each granted word. Clear makes it increment. The address wraps modulo 2^16.
- R4: Mode bit 6 set keeps the address constant for every word.
- R5: Writing the count register with N-1 gives N words. `term_cnt` is high exactly on the granted word in which the count passes from 0 to all ones.
- R6: Single mode (bits [5:4] = 1) drops `bus_req` in the cycle after every granted word.
- R7: Block mode (bits [5:4] = 2) keeps `bus_req` high from start to terminal count, even when `dev_req` falls.
- R8: Demand mode (bits [5:4] = 0) drops `bus_req` in the same cycle `dev_req` falls. It resumes from the unchanged address once `dev_req` returns.
- R9: With mode bit 2 clear, terminal count masks the channel. Requests are then ignored until the address or count register is written.
- R10: With mode bit 2 set, terminal count reloads the address and count from the last written values, and the channel stays unmasked.
- R11: Transfer-mode code 3 never raises `bus_req`.
- R12: Sixteen words from address 0x0000 counting up, and sixteen from 0x0010 counting down, produce consecutive addresses with terminal count on the sixteenth word.
- R13: Register select `cfg_sel` is 0 for mode, 1 for address and 2 for count. Writing the address or count loads both the reload copy and the working copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 mode, 1 address, 2 count |
| cfg_wdata | input | 16 | Write data (mode uses bits [6:0]) |
| dev_req | input | 1 | Peripheral request |
| grant | input | 1 | Grant from the external arbiter; one word per granted cycle |
| bus_req | output | 1 | Request to the arbiter |
| mem_addr | output | 16 | Current memory address |
| rd_stb | output | 1 | Memory read strobe for the granted word |
| wr_stb | output | 1 | Memory write strobe for the granted word |
| term_cnt | output | 1 | High on the final granted word of a run |

## Verification
The assertions check these rules on every cycle:
- the two strobes are never high together, and a strobe always comes with a grant;
- verify passes stay silent on both strobes;
- the address moves by exactly one, or stays fixed under hold;
- single mode releases the request after each word, and block mode keeps it;
- terminal count without re-arm is followed by a dropped request;
- the unused mode code never requests.

Only the bench's scenarios show the following, because they depend on sequences of programming and requests:
- the word count reaching terminal count on the right word;
- the re-arm returning to the written start address;
- demand pause and resume from the same address;
- the mask lifting only after a register write.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        XT_VERIFY = 2'd0,
        XT_WRITE  = 2'd1,
        XT_READ   = 2'd2,
        XT_BAD    = 2'd3
    } xtype_e;

    typedef enum logic [1:0] {
        XM_DEMAND = 2'd0,
        XM_SINGLE = 2'd1,
        XM_BLOCK  = 2'd2,
        XM_NONE   = 2'd3
    } xmode_e;

    // bit 6 hold, [5:4] transfer mode, 3 decrement, 2 re-arm, [1:0] type
    typedef struct packed {
        logic   hold;
        xmode_e xm;
        logic   dec;
        logic   rearm;
        xtype_e xt;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef enum logic [1:0] {
        SEL_MODE  = 2'd0,
        SEL_ADDR  = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_NONE  = 2'd3
    } sel_e;

    typedef enum logic {
        S_IDLE   = 1'b0,
        S_ACTIVE = 1'b1
    } state_e;

endpackage

// File: rtl/dma_chan_addr.sv
module dma_chan_addr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic          dec,
    input  logic          hold,
    input  logic          reload,
    output logic [AW-1:0] cur
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cur    <= '0;
        end else if (load) begin
            base_q <= load_val;
            cur    <= load_val;
        end else if (reload) begin
            cur <= base_q;
        end else if (step && !hold) begin
            cur <= dec ? cur - ONE : cur + ONE;
        end
    end
endmodule

// File: rtl/dma_chan_count.sv
module dma_chan_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          step,
    input  logic          reload,
    output logic          at_zero
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] base_q;
    logic [CW-1:0] cur_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (load) begin
            base_q <= load_val;
            cur_q  <= load_val;
        end else if (reload) begin
            cur_q <= base_q;
        end else if (step) begin
            cur_q <= cur_q - ONE;
        end
    end

    assign at_zero = (cur_q == '0);
endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_chan_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t mode,
    input  logic  unmask,
    input  logic  dev_req,
    input  logic  grant,
    input  logic  cnt_zero,
    output logic  bus_req,
    output logic  xfer,
    output logic  tc,
    output logic  rd_stb,
    output logic  wr_stb
);
    state_e state_q, state_d;
    logic   mask_q;
    logic   usable;

    assign usable = (mode.xt != XT_BAD) && (mode.xm != XM_NONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            mask_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            if (unmask)
                mask_q <= 1'b0;
            else if (tc && !mode.rearm)
                mask_q <= 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (!mask_q && usable && dev_req)
                    state_d = S_ACTIVE;
            end
            S_ACTIVE: begin
                if (!usable)
                    state_d = S_IDLE;
                else if (tc)
                    state_d = S_IDLE;
                else if (mode.xm == XM_SINGLE && xfer)
                    state_d = S_IDLE;
                else if (mode.xm == XM_DEMAND && !dev_req)
                    state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        bus_req = (state_q == S_ACTIVE) && usable &&
                  !(mode.xm == XM_DEMAND && !dev_req);
        xfer    = bus_req && grant;
        tc      = xfer && cnt_zero;
        rd_stb  = xfer && (mode.xt == XT_READ);
        wr_stb  = xfer && (mode.xt == XT_WRITE);
    end
endmodule

// File: rtl/dma_chan_unit.sv
module dma_chan_unit
    import dma_chan_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          dev_req,
    input  logic          grant,
    output logic          bus_req,
    output logic [AW-1:0] mem_addr,
    output logic          rd_stb,
    output logic          wr_stb,
    output logic          term_cnt
);
    mode_t mode_q;
    logic  wr_addr, wr_cnt, wr_mode;
    logic  xfer, cnt_zero, reload;

    assign wr_mode = cfg_we && (sel_e'(cfg_sel) == SEL_MODE);
    assign wr_addr = cfg_we && (sel_e'(cfg_sel) == SEL_ADDR);
    assign wr_cnt  = cfg_we && (sel_e'(cfg_sel) == SEL_COUNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= '0;
        else if (wr_mode)
            mode_q <= mode_t'(cfg_wdata[MODE_W-1:0]);
    end

    assign reload = term_cnt && mode_q.rearm;

    dma_chan_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .unmask   (wr_addr || wr_cnt),
        .dev_req  (dev_req),
        .grant    (grant),
        .cnt_zero (cnt_zero),
        .bus_req  (bus_req),
        .xfer     (xfer),
        .tc       (term_cnt),
        .rd_stb   (rd_stb),
        .wr_stb   (wr_stb)
    );

    dma_chan_addr #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_addr),
        .load_val (AW'(cfg_wdata)),
        .step     (xfer),
        .dec      (mode_q.dec),
        .hold     (mode_q.hold),
        .reload   (reload),
        .cur      (mem_addr)
    );

    dma_chan_count #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_cnt),
        .load_val (CW'(cfg_wdata)),
        .step     (xfer),
        .reload   (reload),
        .at_zero  (cnt_zero)
    );
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk
    import dma_chan_pkg::*;
#(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic          grant,
    input logic          bus_req,
    input logic          term_cnt,
    input logic          rd_stb,
    input logic          wr_stb,
    input logic [AW-1:0] addr,
    input mode_t         mode
);
    logic xfer_s;
    assign xfer_s = bus_req && grant;

    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb));

    p_strobe_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_stb) |-> (grant && bus_req));

    p_verify_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.xt == XT_VERIFY) |-> (!rd_stb && !wr_stb));

    p_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_s && !term_cnt && !mode.hold && !mode.dec && !cfg_we)
        |=> addr == AW'($past(addr) + AW'(1)));

    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_s && !term_cnt && !mode.hold && mode.dec && !cfg_we)
        |=> addr == AW'($past(addr) - AW'(1)));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_s && !term_cnt && mode.hold && !cfg_we) |=> $stable(addr));

    p_tc_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        term_cnt |-> grant);

    p_single_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_s && mode.xm == XM_SINGLE) |=> !bus_req);

    p_block_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_s && !term_cnt && mode.xm == XM_BLOCK && !cfg_we) |=> bus_req);

    p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (term_cnt && !mode.rearm && !cfg_we) |=> !bus_req);

    p_unused_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.xm == XM_NONE) |-> !bus_req);
endmodule

bind dma_chan_unit dma_chan_chk #(.AW(AW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .grant    (grant),
    .bus_req  (bus_req),
    .term_cnt (term_cnt),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .addr     (mem_addr),
    .mode     (mode_q)
);

// File: tb/test_dma_chan_unit.sv
module test_dma_chan_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        dev_req = 1'b0;
    logic        grant = 1'b0;
    logic        bus_req, rd_stb, wr_stb, term_cnt;
    logic [15:0] mem_addr;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dma_chan_unit i_dma_chan_unit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dev_req(dev_req), .grant(grant),
        .bus_req(bus_req), .mem_addr(mem_addr), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .term_cnt(term_cnt)
    );

    // {mode[7:0], base[15:0], count-1[15:0]}
    localparam int NV = 5;
    localparam logic [39:0] VEC [NV] = '{
        {8'h22, 16'h0000, 16'h000F},  // R12 read, up, block, 16 words
        {8'h29, 16'h0010, 16'h000F},  // R12 write, down, block, 16 words
        {8'h00, 16'h0100, 16'h0003},  // R2 verify, up, demand
        {8'h52, 16'h0040, 16'h0004},  // R4 read, hold, single
        {8'h19, 16'h0001, 16'h0002}   // R3 write, down, single, wraps
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic program_chan(input logic [7:0] m, input logic [15:0] b, input logic [15:0] c);
        cfg(2'd0, {8'h00, m});
        cfg(2'd1, b);
        cfg(2'd2, c);
    endtask

    // one cycle: drive request, arbiter grants if enabled and requested
    task automatic cyc(input logic rq, input logic gen);
        @(negedge clk);
        dev_req = rq;
        #1 grant = bus_req & gen;
        #1;
    endtask

    task automatic run_words(input logic [7:0] m, input logic [15:0] b,
                             input logic [15:0] c, input int words, input string tag);
        int seen = 0;
        int guard = 0;
        while (seen < words && guard < 400) begin
            cyc(1'b1, 1'b1);
            guard++;
            if (grant) begin
                int idx = seen % (int'(c) + 1);
                logic [15:0] ea = m[6] ? b : (m[3] ? b - 16'(idx) : b + 16'(idx));
                check({tag, " R3/R4 addr"}, mem_addr, ea);
                check({tag, " R2 rd"}, rd_stb, m[1:0] == 2'd2);
                check({tag, " R2 wr"}, wr_stb, m[1:0] == 2'd1);
                check({tag, " R5 tc"}, term_cnt, idx == int'(c));
                seen++;
            end
        end
        check({tag, " R5 word count"}, seen, words);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state and masked channel
        cyc(1'b0, 1'b0);
        check("R1 bus_req", bus_req, 1'b0);
        check("R1 term_cnt", term_cnt, 1'b0);
        check("R1 strobes", {rd_stb, wr_stb}, 2'b00);
        check("R1 addr", mem_addr, 16'h0000);
        cfg(2'd0, 16'h0022);
        for (int k = 0; k < 3; k++) begin
            cyc(1'b1, 1'b1);
            check("R1 masked after reset", bus_req, 1'b0);
        end

        // vector table
        for (int v = 0; v < NV; v++) begin
            program_chan(VEC[v][39:32], VEC[v][31:16], VEC[v][15:0]);
            run_words(VEC[v][39:32], VEC[v][31:16], VEC[v][15:0],
                      int'(VEC[v][15:0]) + 1, $sformatf("vec%0d", v));
            cyc(1'b0, 1'b0);
            check("R9 idle after tc", bus_req, 1'b0);
        end

        // R9 masked after tc until reprogram
        for (int k = 0; k < 3; k++) begin
            cyc(1'b1, 1'b1);
            check("R9 masked", bus_req, 1'b0);
        end
        cfg(2'd2, 16'h0001);
        cyc(1'b1, 1'b0);
        cyc(1'b1, 1'b0);
        check("R9 unmasked by count write", bus_req, 1'b1);
        // R6 single releases after word
        cyc(1'b1, 1'b1);
        check("R6 granted word", wr_stb, 1'b1);
        cyc(1'b1, 1'b1);
        check("R6 released", bus_req, 1'b0);
        cyc(1'b0, 1'b0);

        // R7 block keeps request with dev_req low
        program_chan(8'h22, 16'h0200, 16'h0007);
        cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b1);
        check("R7 req held", bus_req, 1'b1);
        check("R7 addr first", mem_addr, 16'h0200);
        cyc(1'b0, 1'b1);
        check("R7 req held 2", bus_req, 1'b1);
        check("R7 addr second", mem_addr, 16'h0201);
        for (int k = 2; k < 8; k++) begin
            cyc(1'b0, 1'b1);
            check("R7 block word", mem_addr, 16'h0200 + 16'(k));
            check("R7 block tc", term_cnt, k == 7);
        end
        cyc(1'b0, 1'b0);
        check("R7 drop after tc", bus_req, 1'b0);

        // R8 demand pause and resume
        program_chan(8'h02, 16'h0300, 16'h0005);
        cyc(1'b1, 1'b1);
        cyc(1'b1, 1'b1);
        check("R8 first word", mem_addr, 16'h0300);
        check("R8 first rd", rd_stb, 1'b1);
        cyc(1'b0, 1'b1);
        check("R8 pause req", bus_req, 1'b0);
        check("R8 pause no strobe", rd_stb, 1'b0);
        cyc(1'b0, 1'b1);
        check("R8 still paused", bus_req, 1'b0);
        cyc(1'b1, 1'b1);
        cyc(1'b1, 1'b1);
        check("R8 resume req", bus_req, 1'b1);
        check("R8 resume addr", mem_addr, 16'h0301);
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b0);

        // R10 re-arm reloads address and count
        program_chan(8'h26, 16'h0020, 16'h0001);
        run_words(8'h26, 16'h0020, 16'h0001, 6, "R10 rearm");

        // R11 unused transfer mode
        cfg(2'd0, 16'h0032);
        for (int k = 0; k < 3; k++) begin
            cyc(1'b1, 1'b1);
            check("R11 unused no req", bus_req, 1'b0);
        end

        // R2 illegal type never requests
        cfg(2'd0, 16'h0023);
        cfg(2'd1, 16'h0400);
        for (int k = 0; k < 3; k++) begin
            cyc(1'b1, 1'b1);
            check("R2 illegal no req", bus_req, 1'b0);
        end
        check("R13 addr load", mem_addr, 16'h0400);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule